// File: doc/BRIEF.md
# Cross-Context Register Write Dispatcher

This block takes one coprocessor-0 instruction that copies a value into a register of another hardware thread context. It checks the instruction's fixed fields. It decides whether the write may go ahead at all, and it decodes which register class, which register index and which 32-bit half should receive the source operand. The result is a single registered write request, or a registered undefined-access pulse when the encoding has no defined meaning. Downstream register files act on that request. Those files, the pipeline and any exception handling sit outside this block.

The issuing pipeline supplies several inputs with the strobe:

- the instruction word and the source operand;
- the index of the target context and the highest implemented context number;
- the issuer's privilege to reach other virtual processors;
- the issuer's own virtual-processor binding, and a table holding each context's binding;
- a flag saying whether floating-point and general register widths match.

Top module: `xctx_write_dispatch`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and directly after it is released, `wr_en_o` and `undef_o` are 0.
- R2: Every output is registered. A request sampled with `issue_i` high shows up on the outputs at the next rising clock edge. A cycle with `issue_i` low gives `wr_en_o`=0 and `undef_o`=0 one clock later.
- R3: An instruction is accepted only when it meets all of these field values. If any one fails, the instruction causes neither a write nor the undefined flag.
  - bits 31:26 = 010000
  - bits 25:21 = 01100
  - bit 3 = 0

  The other fields are placed as follows:

  | Field | Bits |
  |-------|------|
  | rt | 20:16 (source tag, not used) |
  | rd | 15:11 |
  | rx | 10:6 |
  | u | 5 |
  | h | 4 |
  | sel | 2:0 |
- R4: If the target context index is greater than `max_ctx_i`, the operation is a no-op: no write and no flag, even when the encoding is undefined. A target equal to `max_ctx_i` is allowed.
- R5: If `mvp_priv_i` is 0 and the target's binding differs from `own_vpe_i`, the operation is a no-op. The target's binding is table entry `ctx_vpe_tbl_i[i*VPE_W +: VPE_W]` for context i. If `mvp_priv_i` is 1, the binding is ignored.
- R6: With u=0, the class is 0 (coprocessor-0). The index holds sel in bits 7:5 and rd in bits 4:0, with the upper index bits zero. `wr_hi_o` equals h.
- R7: With u=1 and sel=0, the class is 1 (general register), the index is rd, and `wr_hi_o` is 0.
- R8: With u=1 and sel=1, the class is 2 (accumulator/special) and the index is rd. The allowed rd values are 0, 1, 2, 4, 5, 6, 8, 9, 10, 12, 13, 14 and 16. Any other rd sets the undefined flag.
- R9: With u=1 and sel=2, the class is 3 (floating-point register) and the index is rd.
  - When `width_match_i`=1, h=0 writes with `wr_hi_o`=0, and h=1 is undefined.
  - When `width_match_i`=0, `wr_hi_o` equals h.
- R10: With u=1, sel=3 selects class 4 (FP control), with index rd and `wr_hi_o`=0. Sel=4 selects class 5 (coprocessor-2 data) and sel=5 selects class 6 (coprocessor-2 control). For both, the index is rx in bits 9:5 and rd in bits 4:0, and `wr_hi_o` equals h.
- R11: With u=1, sel=6 and sel=7 are undefined.
- R12: `wr_en_o` and `undef_o` are never 1 together. When `wr_en_o` is 1, `wr_data_o` equals the source operand and `wr_ctx_o` equals the target index that was sampled with the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| issue_i | input | 1 | Request strobe |
| instr_i | input | 32 | Instruction word |
| src_data_i | input | DATA_W | Source operand |
| tgt_ctx_i | input | CTX_W | Target context index |
| max_ctx_i | input | CTX_W | Highest implemented context number |
| mvp_priv_i | input | 1 | Issuer may reach contexts of any virtual processor |
| own_vpe_i | input | VPE_W | Issuer's virtual-processor binding |
| ctx_vpe_tbl_i | input | NUM_CTX*VPE_W | Binding of every context |
| width_match_i | input | 1 | FP and general register widths are equal |
| wr_en_o | output | 1 | Write request valid |
| wr_ctx_o | output | CTX_W | Context to be written |
| wr_class_o | output | 3 | Register class code |
| wr_idx_o | output | 10 | Register index in that class |
| wr_hi_o | output | 1 | 1 selects bits 63:32, 0 selects bits 31:0 |
| wr_data_o | output | DATA_W | Write data |
| undef_o | output | 1 | Undefined-access pulse |

## Verification
The bench targets the gaps in the accumulator-select map: rd 3, 7, 11, 15 and 17. A decoder that only compared ranges would accept these and write a register that does not exist. It also checks that the no-op gates take priority over the undefined flag; a design with the order reversed would report an illegal encoding aimed at a context it may not touch. The half-select on floating-point writes is exercised under both width settings, where a wrong mapping would clobber the wrong half or write when it should flag. The bench also covers the range boundary where the target equals the maximum, and a set bit 3 in an otherwise valid word.

// File: rtl/xctx_pkg.sv
package xctx_pkg;
   localparam int IDX_W = 10;
   localparam logic [5:0] OPC_COP0 = 6'b010000;
   localparam logic [4:0] SUB_MOVE = 5'b01100;

   typedef enum logic [2:0] {
      CLS_CP0  = 3'd0,
      CLS_GPR  = 3'd1,
      CLS_ACC  = 3'd2,
      CLS_FPR  = 3'd3,
      CLS_FPCR = 3'd4,
      CLS_CP2D = 3'd5,
      CLS_CP2C = 3'd6
   } reg_class_e;

   typedef struct packed {
      logic [4:0] rt;
      logic [4:0] rd;
      logic [4:0] rx;
      logic       u;
      logic       h;
      logic [2:0] sel;
   } mv_fields_t;
endpackage

// File: rtl/xctx_fmt_decode.sv
module xctx_fmt_decode
   import xctx_pkg::*;
(
   input  logic [31:0] instr_i,
   output mv_fields_t  fields_o,
   output logic        fmt_ok_o
);
   always_comb begin
      fields_o.rt  = instr_i[20:16];
      fields_o.rd  = instr_i[15:11];
      fields_o.rx  = instr_i[10:6];
      fields_o.u   = instr_i[5];
      fields_o.h   = instr_i[4];
      fields_o.sel = instr_i[2:0];
      fmt_ok_o     = (instr_i[31:26] == OPC_COP0) &&
                     (instr_i[25:21] == SUB_MOVE) &&
                     !instr_i[3];
   end
endmodule

// File: rtl/xctx_ctx_gate.sv
module xctx_ctx_gate #(
   parameter int NUM_CTX = 8,
   parameter int VPE_W   = 2,
   localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
   input  logic [CTX_W-1:0]         tgt_ctx_i,
   input  logic [CTX_W-1:0]         max_ctx_i,
   input  logic                     mvp_priv_i,
   input  logic [VPE_W-1:0]         own_vpe_i,
   input  logic [NUM_CTX*VPE_W-1:0] ctx_vpe_tbl_i,
   output logic                     noop_o
);
   logic [VPE_W-1:0] bind_arr [NUM_CTX];

   for (genvar gi = 0; gi < NUM_CTX; gi++) begin : g_unpack
      assign bind_arr[gi] = ctx_vpe_tbl_i[gi*VPE_W +: VPE_W];
   end

   logic [VPE_W-1:0] tgt_bind;
   logic             tgt_known;

   always_comb begin
      tgt_bind  = '0;
      tgt_known = 1'b0;
      for (int i = 0; i < NUM_CTX; i++) begin
         if (tgt_ctx_i == CTX_W'(i)) begin
            tgt_bind  = bind_arr[i];
            tgt_known = 1'b1;
         end
      end
   end

   logic out_of_range;
   logic foreign;

   assign out_of_range = (tgt_ctx_i > max_ctx_i) || !tgt_known;
   assign foreign      = !mvp_priv_i && (tgt_bind != own_vpe_i);
   assign noop_o       = out_of_range || foreign;
endmodule

// File: rtl/xctx_target_map.sv
module xctx_target_map
   import xctx_pkg::*;
(
   input  mv_fields_t       f_i,
   input  logic             width_match_i,
   output reg_class_e       cls_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             hi_o,
   output logic             undef_o
);
   logic acc_ok;
   assign acc_ok = (f_i.rd == 5'd16) || ((f_i.rd < 5'd15) && (f_i.rd[1:0] != 2'b11));

   always_comb begin
      cls_o   = CLS_CP0;
      idx_o   = IDX_W'(f_i.rd);
      hi_o    = 1'b0;
      undef_o = 1'b0;
      if (!f_i.u) begin
         idx_o = IDX_W'({f_i.sel, f_i.rd});
         hi_o  = f_i.h;
      end else begin
         unique case (f_i.sel)
            3'd0: cls_o = CLS_GPR;
            3'd1: begin
               cls_o   = CLS_ACC;
               undef_o = !acc_ok;
            end
            3'd2: begin
               cls_o = CLS_FPR;
               if (width_match_i) undef_o = f_i.h;
               else               hi_o    = f_i.h;
            end
            3'd3: cls_o = CLS_FPCR;
            3'd4, 3'd5: begin
               cls_o = (f_i.sel == 3'd4) ? CLS_CP2D : CLS_CP2C;
               idx_o = {f_i.rx, f_i.rd};
               hi_o  = f_i.h;
            end
            default: undef_o = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/xctx_write_dispatch.sv
module xctx_write_dispatch
   import xctx_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int NUM_CTX = 8,
   parameter int VPE_W   = 2,
   localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     issue_i,
   input  logic [31:0]              instr_i,
   input  logic [DATA_W-1:0]        src_data_i,
   input  logic [CTX_W-1:0]         tgt_ctx_i,
   input  logic [CTX_W-1:0]         max_ctx_i,
   input  logic                     mvp_priv_i,
   input  logic [VPE_W-1:0]         own_vpe_i,
   input  logic [NUM_CTX*VPE_W-1:0] ctx_vpe_tbl_i,
   input  logic                     width_match_i,
   output logic                     wr_en_o,
   output logic [CTX_W-1:0]         wr_ctx_o,
   output logic [2:0]               wr_class_o,
   output logic [IDX_W-1:0]         wr_idx_o,
   output logic                     wr_hi_o,
   output logic [DATA_W-1:0]        wr_data_o,
   output logic                     undef_o
);
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end
   if (NUM_CTX < 2) begin : g_bad_ctx
      $error("NUM_CTX must be at least 2");
   end
   if (VPE_W < 1) begin : g_bad_vpe
      $error("VPE_W must be positive");
   end

   mv_fields_t       fld;
   logic             fmt_ok;
   logic             noop;
   reg_class_e       cls_c;
   logic [IDX_W-1:0] idx_c;
   logic             hi_c;
   logic             undef_c;

   xctx_fmt_decode u_fmt (
      .instr_i  (instr_i),
      .fields_o (fld),
      .fmt_ok_o (fmt_ok)
   );

   xctx_ctx_gate #(.NUM_CTX(NUM_CTX), .VPE_W(VPE_W)) u_gate (
      .tgt_ctx_i     (tgt_ctx_i),
      .max_ctx_i     (max_ctx_i),
      .mvp_priv_i    (mvp_priv_i),
      .own_vpe_i     (own_vpe_i),
      .ctx_vpe_tbl_i (ctx_vpe_tbl_i),
      .noop_o        (noop)
   );

   xctx_target_map u_map (
      .f_i           (fld),
      .width_match_i (width_match_i),
      .cls_o         (cls_c),
      .idx_o         (idx_c),
      .hi_o          (hi_c),
      .undef_o       (undef_c)
   );

   logic go;
   assign go = issue_i && fmt_ok && !noop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en_o    <= 1'b0;
         undef_o    <= 1'b0;
         wr_ctx_o   <= '0;
         wr_class_o <= '0;
         wr_idx_o   <= '0;
         wr_hi_o    <= 1'b0;
         wr_data_o  <= '0;
      end else begin
         wr_en_o <= go && !undef_c;
         undef_o <= go && undef_c;
         if (issue_i) begin
            wr_ctx_o   <= tgt_ctx_i;
            wr_class_o <= cls_c;
            wr_idx_o   <= idx_c;
            wr_hi_o    <= hi_c;
            wr_data_o  <= src_data_i;
         end
      end
   end

   // R12: write and undefined pulse are mutually exclusive
   a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_o && undef_o));

   // R2: no strobe, no output activity one cycle later
   a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_i |=> (!wr_en_o && !undef_o));

   // R3: malformed word produces nothing
   a_r3_bad_format: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && !fmt_ok) |=> (!wr_en_o && !undef_o));

   // R4: target beyond the implemented range is a no-op
   a_r4_range: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && (tgt_ctx_i > max_ctx_i)) |=> (!wr_en_o && !undef_o));

   // R12: data and context follow the request
   a_r12_payload: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i |=> (wr_data_o == $past(src_data_i) && wr_ctx_o == $past(tgt_ctx_i)));

   // R7: general register writes are always the low half
   a_r7_gpr_low: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && wr_class_o == 3'd1) |-> !wr_hi_o);
endmodule

// File: tb/xctx_write_dispatch_bench.sv
module xctx_write_dispatch_bench;
   localparam int DATA_W  = 32;
   localparam int NUM_CTX = 8;
   localparam int VPE_W   = 2;
   localparam int CTX_W   = 3;

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic                     issue_i = 1'b0;
   logic [31:0]              instr_i = '0;
   logic [DATA_W-1:0]        src_data_i = '0;
   logic [CTX_W-1:0]         tgt_ctx_i = '0;
   logic [CTX_W-1:0]         max_ctx_i = '0;
   logic                     mvp_priv_i = 1'b0;
   logic [VPE_W-1:0]         own_vpe_i = '0;
   logic [NUM_CTX*VPE_W-1:0] ctx_vpe_tbl_i = '0;
   logic                     width_match_i = 1'b0;
   logic                     wr_en_o;
   logic [CTX_W-1:0]         wr_ctx_o;
   logic [2:0]               wr_class_o;
   logic [9:0]               wr_idx_o;
   logic                     wr_hi_o;
   logic [DATA_W-1:0]        wr_data_o;
   logic                     undef_o;

   xctx_write_dispatch #(.DATA_W(DATA_W), .NUM_CTX(NUM_CTX), .VPE_W(VPE_W)) u_xctx_write_dispatch (
      .clk, .rst_n, .issue_i, .instr_i, .src_data_i, .tgt_ctx_i, .max_ctx_i,
      .mvp_priv_i, .own_vpe_i, .ctx_vpe_tbl_i, .width_match_i,
      .wr_en_o, .wr_ctx_o, .wr_class_o, .wr_idx_o, .wr_hi_o, .wr_data_o, .undef_o
   );

   always #5 clk = ~clk;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   int e_en, e_un, e_cls, e_idx, e_hi;

   function automatic logic [31:0] mk(input int u, input int h, input int sel,
                                      input int rd, input int rx);
      logic [31:0] w;
      w = 32'h4180_0000;
      w[15:11] = rd[4:0];
      w[10:6]  = rx[4:0];
      w[5]     = u[0];
      w[4]     = h[0];
      w[2:0]   = sel[2:0];
      return w;
   endfunction

   task automatic model();
      int u, h, sel, rd, rx, tb, blocked, bad;
      u = instr_i[5]; h = instr_i[4]; sel = instr_i[2:0];
      rd = instr_i[15:11]; rx = instr_i[10:6];
      tb = ctx_vpe_tbl_i[tgt_ctx_i*VPE_W +: VPE_W];
      e_en = 0; e_un = 0; e_cls = 0; e_idx = rd; e_hi = 0; bad = 0;
      if (!issue_i) return;
      if (instr_i[31:26] != 6'o20 || instr_i[25:21] != 5'd12 || instr_i[3]) return;
      blocked = (tgt_ctx_i > max_ctx_i) || (!mvp_priv_i && tb != own_vpe_i);
      if (blocked) return;
      if (u == 0) begin
         e_cls = 0; e_idx = sel * 32 + rd; e_hi = h;
      end else if (sel == 0) e_cls = 1;
      else if (sel == 1) begin
         e_cls = 2;
         bad = !(rd inside {0,1,2,4,5,6,8,9,10,12,13,14,16});
      end else if (sel == 2) begin
         e_cls = 3;
         if (width_match_i) bad = h; else e_hi = h;
      end else if (sel == 3) e_cls = 4;
      else if (sel == 4 || sel == 5) begin
         e_cls = sel + 1; e_idx = rx * 32 + rd; e_hi = h;
      end else bad = 1;
      e_en = !bad; e_un = bad;
   endtask

   logic [DATA_W-1:0] e_data;
   logic [CTX_W-1:0]  e_ctx;

   task automatic compare(input string tag);
      bit ok;
      checks++;
      ok = (wr_en_o == e_en[0]) && (undef_o == e_un[0]);
      if (ok && e_en != 0)
         ok = (wr_class_o == e_cls[2:0]) && (wr_idx_o == e_idx[9:0]) &&
              (wr_hi_o == e_hi[0]) && (wr_data_o == e_data) && (wr_ctx_o == e_ctx);
      if (!ok) begin
         failures++;
         $display("FAIL %s: got en=%0d un=%0d cls=%0d idx=%0d hi=%0d data=%h ctx=%0d exp en=%0d un=%0d cls=%0d idx=%0d hi=%0d data=%h ctx=%0d",
                  tag, wr_en_o, undef_o, wr_class_o, wr_idx_o, wr_hi_o, wr_data_o, wr_ctx_o,
                  e_en, e_un, e_cls, e_idx, e_hi, e_data, e_ctx);
      end
   endtask

   task automatic go(input string tag, input logic [31:0] ins, input int tgt, input int mx,
                     input int priv, input int wm);
      @(negedge clk);
      issue_i = 1'b1; instr_i = ins; tgt_ctx_i = tgt[CTX_W-1:0]; max_ctx_i = mx[CTX_W-1:0];
      mvp_priv_i = priv[0]; width_match_i = wm[0]; src_data_i = $urandom;
      model(); e_data = src_data_i; e_ctx = tgt_ctx_i;
      @(negedge clk);
      compare(tag);
      issue_i = 1'b0;
   endtask

   initial begin
      #1_500_000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog: got hung run exp completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      own_vpe_i = 2'd1;
      for (int i = 0; i < NUM_CTX; i++) ctx_vpe_tbl_i[i*VPE_W +: VPE_W] = (i < 4) ? 2'd1 : 2'd2;
      repeat (3) @(negedge clk);
      e_en = 0; e_un = 0;
      compare("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 after reset");

      go("R6 cp0 hi", mk(0,1,5,12,0), 2, 7, 0, 1);
      go("R6 cp0 lo", mk(0,0,0,31,3), 0, 7, 0, 0);
      @(negedge clk); e_en = 0; e_un = 0; compare("R2 idle after strobe");
      go("R7 gpr", mk(1,1,0,31,0), 1, 7, 0, 1);
      go("R8 acc 16", mk(1,0,1,16,0), 3, 7, 0, 1);
      go("R8 acc 14", mk(1,0,1,14,0), 3, 7, 0, 1);
      go("R8 acc gap 3", mk(1,0,1,3,0), 3, 7, 0, 1);
      go("R8 acc gap 15", mk(1,0,1,15,0), 3, 7, 0, 1);
      go("R8 acc 17", mk(1,0,1,17,0), 3, 7, 0, 1);
      go("R9 fpr wm lo", mk(1,0,2,7,0), 2, 7, 0, 1);
      go("R9 fpr wm hi undef", mk(1,1,2,7,0), 2, 7, 0, 1);
      go("R9 fpr wide hi", mk(1,1,2,7,0), 2, 7, 0, 0);
      go("R10 fpcr", mk(1,1,3,25,0), 2, 7, 0, 0);
      go("R10 cp2 data", mk(1,1,4,3,5), 2, 7, 0, 0);
      go("R10 cp2 ctrl", mk(1,0,5,31,31), 2, 7, 0, 0);
      go("R11 sel6", mk(1,0,6,0,0), 2, 7, 0, 0);
      go("R11 sel7", mk(1,0,7,0,0), 2, 7, 0, 0);
      go("R3 bad opcode", mk(1,0,0,4,0) ^ 32'h0400_0000, 2, 7, 0, 0);
      go("R3 bad sub", mk(1,0,0,4,0) ^ 32'h0020_0000, 2, 7, 0, 0);
      go("R3 bit3", mk(1,0,0,4,0) | 32'h8, 2, 7, 0, 0);
      go("R4 beyond max", mk(1,0,0,4,0), 5, 4, 1, 0);
      go("R4 at max", mk(1,0,0,4,0), 4, 4, 1, 0);
      go("R4 undef beyond max", mk(1,0,7,4,0), 5, 4, 1, 0);
      go("R5 foreign no priv", mk(1,0,0,4,0), 6, 7, 0, 0);
      go("R5 foreign undef no priv", mk(1,0,6,4,0), 6, 7, 0, 0);
      go("R5 foreign priv", mk(1,0,0,4,0), 6, 7, 1, 0);

      for (int n = 0; n < 3000; n++) begin
         @(negedge clk);
         if (n > 0) compare("R12 random");
         issue_i = ($urandom_range(0, 3) != 0);
         instr_i = mk($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,7),
                      $urandom_range(0,31), $urandom_range(0,31));
         if ($urandom_range(0, 9) == 0) instr_i = instr_i ^ (32'h1 << $urandom_range(3, 31));
         tgt_ctx_i = $urandom; max_ctx_i = $urandom; mvp_priv_i = $urandom;
         own_vpe_i = $urandom; ctx_vpe_tbl_i = $urandom; width_match_i = $urandom;
         src_data_i = $urandom;
         model(); e_data = src_data_i; e_ctx = tgt_ctx_i;
      end
      @(negedge clk);
      compare("R12 random last");
      issue_i = 1'b0;
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule